// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block is the group-address stage of a receive-side destination filter for a 10G Ethernet MAC. It keeps a table of 512 one-bit bins. The six destination-address bytes of each incoming frame arrive one per clock, in wire order. While they arrive, the block folds them into a CRC-32 and turns the final value into a 9-bit bin number. When the last byte is taken, it looks up that bin. One cycle later it emits a single-cycle verdict that carries the bin number, whether the address was a group address, whether the bin matched, and whether the frame is to be accepted.

Software maintains the table one bin at a time with a 32-bit control word written through a write strobe. The word holds a bin number and a set/clear flag. A separate clear-all input wipes the whole table in one cycle. A promiscuous input makes every verdict an accept. Individual (unicast) destinations never match the table and are left to other filters.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset every bin is clear and all verdict outputs are low, so the first group address looked up does not match.
- R2: A control write with bit 9 set to 1 sets the bin numbered by bits [8:0]; bits [31:10] of the word are ignored.
- R3: A control write with bit 9 set to 0 clears the bin numbered by bits [8:0] and leaves the other bins as they were.
- R4: The bin number equals bits [31:23] of the bit-reversed CRC-32 of the six address bytes. The CRC processes each byte LSB first, uses polynomial 0x04C11DB7, starts from 0xFFFFFFFF and applies no final inversion; byte 0 (a[7:0]) goes first.
- R5: For a group address (bit 0 of address byte 0 is 1), the verdict reports a hit and an accept exactly when its bin is set.
- R6: For an individual address (bit 0 of byte 0 is 0), the verdict reports group low and never a hit, whatever the table holds; it accepts only under promiscuous mode.
- R7: When promiscuous is high in the cycle of the sixth byte, the verdict is an accept for any address.
- R8: The verdict-valid output is a one-cycle pulse, high in the cycle right after the sixth byte is taken.
- R9: A table write in the same cycle as the sixth byte does not change that frame's verdict; it applies from the next frame.
- R10: Clear-all zeroes every bin in one cycle and takes priority over a table write in the same cycle.
- R11: A byte marked first restarts the address, dropping any partial one; bytes not marked first while no address is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr | input | 1 | Table control write strobe |
| tbl_word | input | 32 | Control word: [8:0] bin number, [9] set(1)/clear(0) |
| tbl_wipe | input | 1 | Clear every bin |
| promisc | input | 1 | Accept all frames |
| da_valid | input | 1 | Address byte present |
| da_first | input | 1 | Byte is address byte 0 |
| da_byte | input | 8 | Address byte, wire order |
| vd_valid | output | 1 | Verdict pulse |
| vd_group | output | 1 | Address was a group address |
| vd_hit | output | 1 | Group address bin was set |
| vd_accept | output | 1 | Frame accepted by this filter |
| vd_bin | output | 9 | Bin number computed for the address |

## Verification
The assertions rely on addresses arriving as contiguous runs that each start with a first-marked byte, so that two verdict pulses are always at least six cycles apart. They also rely on promiscuous mode and table writes being sampled only at clock edges. The stimulus drives all inputs on the falling edge, sends each address in six back-to-back bytes, and keeps deliberate partial or unmarked runs to the R11 test. The main sweep sets every even bin and checks that each looked-up address hits exactly when its independently computed bin is even.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int IDX_W      = 9;
    localparam int NUM_BINS   = 1 << IDX_W;
    localparam int ADDR_BYTES = 6;
    localparam int CRC_W      = 32;
    localparam int CTRL_W     = 32;
    localparam int SET_BIT    = IDX_W;
    localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;

    typedef logic [IDX_W-1:0] bin_idx_t;
    typedef logic [CRC_W-1:0] crc_t;

    // lookup request produced when the last address byte is taken
    typedef struct packed {
        logic     valid;
        logic     group;
        bin_idx_t bin;
    } lookup_req_t;

    // decoded table command
    typedef struct packed {
        logic     wr;
        logic     set;
        bin_idx_t bin;
    } tbl_cmd_t;

    // registered verdict
    typedef struct packed {
        logic     valid;
        logic     group;
        logic     hit;
        logic     accept;
        bin_idx_t bin;
    } verdict_t;

    // one byte of a reflected CRC, LSB of the byte first
    function automatic crc_t crc_fold_byte(crc_t c, logic [7:0] d);
        crc_t r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // top IDX_W bits of the bit-reversed CRC
    function automatic bin_idx_t crc_to_bin(crc_t c);
        bin_idx_t b;
        for (int k = 0; k < IDX_W; k++) b[k] = c[IDX_W-1-k];
        return b;
    endfunction

    function automatic tbl_cmd_t decode_ctrl(logic wr, logic [CTRL_W-1:0] w);
        tbl_cmd_t t;
        t.wr  = wr;
        t.set = w[SET_BIT];
        t.bin = w[IDX_W-1:0];
        return t;
    endfunction

endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
    import mhf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_first,
    input  logic [7:0]  in_byte,
    output lookup_req_t req
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0] cnt_q, pos;
    crc_t             crc_q, seed, crc_nx;
    logic             grp_q, grp_nx, take, last;

    always_comb begin
        seed   = in_first ? CRC_SEED : crc_q;
        crc_nx = crc_fold_byte(seed, in_byte);
        pos    = in_first ? '0 : cnt_q;
        take   = in_valid && (in_first || cnt_q != '0);
        last   = take && (pos == LAST_POS);
        grp_nx = in_first ? in_byte[0] : grp_q;
        req.valid = last;
        req.group = grp_nx;
        req.bin   = crc_to_bin(crc_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            crc_q <= CRC_SEED;
            grp_q <= 1'b0;
        end else if (take) begin
            crc_q <= crc_nx;
            grp_q <= grp_nx;
            cnt_q <= last ? '0 : pos + 1'b1;
        end
    end

    // R11: progress counter never runs past the address length
    p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(ADDR_BYTES));

    // R11: a byte that is neither first nor part of a run changes nothing
    p_idle_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !in_first) |=> (cnt_q == '0));

endmodule

// File: rtl/mhf_bin_table.sv
module mhf_bin_table
    import mhf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wipe,
    input  tbl_cmd_t cmd,
    input  bin_idx_t rd_bin,
    output logic     rd_bit
);
    logic [NUM_BINS-1:0] bins_q;
    logic [NUM_BINS-1:0] we;

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_we
        assign we[g] = cmd.wr && (cmd.bin == bin_idx_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            bins_q <= '0;
        end else begin
            for (int i = 0; i < NUM_BINS; i++)
                if (we[i]) bins_q[i] <= cmd.set;
        end
    end

    assign rd_bit = bins_q[rd_bin];

    // R2: a set command lands in the addressed bin
    p_set_bin_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.set && !wipe) |=> bins_q[$past(cmd.bin)]);

    // R3: a clear command empties the addressed bin
    p_clear_bin_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && !cmd.set && !wipe) |=> !bins_q[$past(cmd.bin)]);

    // R10: wipe empties the whole table on the next cycle
    p_wipe_all_r10: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (bins_q == '0));

    // R3: without a command the table holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!cmd.wr && !wipe) |=> $stable(bins_q));

endmodule

// File: rtl/mhf_verdict.sv
module mhf_verdict
    import mhf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lookup_req_t req,
    input  logic        bin_bit,
    input  logic        promisc,
    output verdict_t    vd
);
    logic hit_nx;

    assign hit_nx = req.group && bin_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            vd <= '0;
        end else begin
            vd.valid <= req.valid;
            if (req.valid) begin
                vd.group  <= req.group;
                vd.bin    <= req.bin;
                vd.hit    <= hit_nx;
                vd.accept <= promisc || hit_nx;
            end else begin
                vd.hit    <= 1'b0;
                vd.accept <= 1'b0;
            end
        end
    end

    // R8: verdict is a single-cycle pulse
    p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        vd.valid |=> !vd.valid);

    // R8: verdict follows the last byte by one cycle
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> vd.valid);

    // R7: promiscuous at the last byte gives an accept
    p_promisc_r7: assert property (@(posedge clk) disable iff (rst)
        (req.valid && promisc) |=> vd.accept);

    // R6: an individual address never matches
    p_unicast_r6: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !req.group) |=> !vd.hit);

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_wr,
    input  logic [CTRL_W-1:0] tbl_word,
    input  logic              tbl_wipe,
    input  logic              promisc,
    input  logic              da_valid,
    input  logic              da_first,
    input  logic [7:0]        da_byte,
    output logic              vd_valid,
    output logic              vd_group,
    output logic              vd_hit,
    output logic              vd_accept,
    output logic [IDX_W-1:0]  vd_bin
);
    lookup_req_t req;
    tbl_cmd_t    cmd;
    verdict_t    vd;
    logic        bin_bit;
    logic        word_unused;

    assign cmd         = decode_ctrl(tbl_wr, tbl_word);
    assign word_unused = ^tbl_word[CTRL_W-1:SET_BIT+1];

    mhf_crc_engine u_crc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (da_valid),
        .in_first (da_first),
        .in_byte  (da_byte),
        .req      (req)
    );

    mhf_bin_table u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wipe   (tbl_wipe),
        .cmd    (cmd),
        .rd_bin (req.bin),
        .rd_bit (bin_bit)
    );

    mhf_verdict u_vd (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .bin_bit (bin_bit),
        .promisc (promisc),
        .vd      (vd)
    );

    assign vd_valid  = vd.valid;
    assign vd_group  = vd.group;
    assign vd_hit    = vd.hit;
    assign vd_accept = vd.accept;
    assign vd_bin    = vd.bin;

    // R5: a hit only ever comes with a group address and an accept
    p_hit_group_r5: assert property (@(posedge clk) disable iff (rst)
        vd_hit |-> (vd_group && vd_accept && vd_valid));

    // R1: outputs are quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!vd_valid && !vd_hit && !vd_accept));

endmodule

// File: tb/test_mcast_hash_filter.sv
module test_mcast_hash_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_wr = 1'b0;
    logic [31:0] tbl_word = '0;
    logic        tbl_wipe = 1'b0;
    logic        promisc = 1'b0;
    logic        da_valid = 1'b0;
    logic        da_first = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        vd_valid, vd_group, vd_hit, vd_accept;
    logic [8:0]  vd_bin;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mcast_hash_filter i_mcast_hash_filter (
        .clk(clk), .rst(rst), .tbl_wr(tbl_wr), .tbl_word(tbl_word),
        .tbl_wipe(tbl_wipe), .promisc(promisc), .da_valid(da_valid),
        .da_first(da_first), .da_byte(da_byte), .vd_valid(vd_valid),
        .vd_group(vd_group), .vd_hit(vd_hit), .vd_accept(vd_accept),
        .vd_bin(vd_bin)
    );

    always @(negedge clk) if (!rst && vd_valid) pulses++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // MSB-first CRC on LSB-first bits: equals the bit-reversed reflected CRC
    function automatic logic [8:0] exp_bin(logic [47:0] a);
        logic [31:0] m = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic fb = m[31] ^ a[8*i+j];
                m = m << 1;
                if (fb) m = m ^ 32'h04C1_1DB7;
            end
        end
        return m[31:23];
    endfunction

    function automatic logic [47:0] mk_addr(int n, bit grp);
        logic [47:0] a;
        a = {32'(n * 32'h9E37_79B1 + 32'h1234_5678), 16'(n * 7919 + 3)};
        a[0] = grp;
        return a;
    endfunction

    task automatic write_ctrl(input logic [31:0] w);
        @(negedge clk); tbl_wr = 1'b1; tbl_word = w;
        @(negedge clk); tbl_wr = 1'b0; tbl_word = '0;
    endtask

    // sends six bytes; optional table write alongside the last byte
    task automatic send_addr(input logic [47:0] a, input bit wr_last, input logic [31:0] w);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            da_valid = 1'b1;
            da_first = (i == 0);
            da_byte  = a[8*i +: 8];
            if (i == 5 && wr_last) begin tbl_wr = 1'b1; tbl_word = w; end
        end
        @(negedge clk);
        da_valid = 1'b0; da_first = 1'b0; tbl_wr = 1'b0; tbl_word = '0;
    endtask

    task automatic expect_verdict(input string tag, input logic [47:0] a,
                                  input bit hit, input bit acc);
        check(vd_valid == 1'b1, {tag, " valid R8"}, vd_valid, 1);
        check(vd_group == a[0], {tag, " group"}, vd_group, a[0]);
        check(vd_bin == exp_bin(a), {tag, " bin R4"}, vd_bin, exp_bin(a));
        check(vd_hit == hit, {tag, " hit"}, vd_hit, hit);
        check(vd_accept == acc, {tag, " accept"}, vd_accept, acc);
        @(negedge clk);
        check(vd_valid == 1'b0, {tag, " pulse width R8"}, vd_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [47:0] a;
        logic [8:0]  b;
        int          p0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs and empty table after reset
        check(!vd_valid && !vd_hit && !vd_accept, "R1 outputs", vd_valid, 0);
        a = mk_addr(7, 1);
        send_addr(a, 0, '0);
        expect_verdict("R1 empty table", a, 0, 0);

        // R2 and R3 with junk in the ignored upper bits
        a = mk_addr(1, 1); b = exp_bin(a);
        write_ctrl(32'hABCD_E000 | 32'h200 | {23'd0, b});
        send_addr(a, 0, '0);
        expect_verdict("R2 set", a, 1, 1);
        write_ctrl(32'h5432_1C00 | {23'd0, b});
        send_addr(a, 0, '0);
        expect_verdict("R3 clear", a, 0, 0);

        // R9: write with the sixth byte applies to the next frame only
        a = mk_addr(2, 1); b = exp_bin(a);
        send_addr(a, 1, 32'h200 | {23'd0, b});
        expect_verdict("R9 same cycle", a, 0, 0);
        send_addr(a, 0, '0);
        expect_verdict("R9 next frame", a, 1, 1);
        write_ctrl({23'd0, b});

        // R5/R4 sweep: every even bin set
        for (int k = 0; k < 256; k++) write_ctrl(32'h200 | (2 * k));
        for (int n = 0; n < 300; n++) begin
            a = mk_addr(n + 100, 1); b = exp_bin(a);
            send_addr(a, 0, '0);
            expect_verdict("R5 sweep", a, !b[0], !b[0]);
        end

        // R6: individual addresses never hit
        for (int n = 0; n < 64; n++) begin
            a = mk_addr(n + 500, 0);
            send_addr(a, 0, '0);
            expect_verdict("R6 unicast", a, 0, 0);
        end
        promisc = 1'b1;
        for (int n = 0; n < 16; n++) begin
            a = mk_addr(n + 600, 0);
            send_addr(a, 0, '0);
            expect_verdict("R6 unicast promisc", a, 0, 1);
        end

        // R7: promiscuous accepts group addresses in empty bins
        for (int n = 0; n < 40; n++) begin
            a = mk_addr(n + 700, 1); b = exp_bin(a);
            send_addr(a, 0, '0);
            expect_verdict("R7 promisc", a, !b[0], 1);
        end
        promisc = 1'b0;

        // R10: wipe in one cycle, priority over a write
        @(negedge clk); tbl_wipe = 1'b1; tbl_wr = 1'b1;
        a = mk_addr(3, 1); b = exp_bin(a);
        tbl_word = 32'h200 | {23'd0, b};
        @(negedge clk); tbl_wipe = 1'b0; tbl_wr = 1'b0; tbl_word = '0;
        send_addr(a, 0, '0);
        expect_verdict("R10 wipe beats write", a, 0, 0);
        for (int n = 0; n < 40; n++) begin
            a = mk_addr(n + 100, 1);
            send_addr(a, 0, '0);
            expect_verdict("R10 wiped", a, 0, 0);
        end

        // R11: partial address restarted by a first byte
        a = mk_addr(4, 1); b = exp_bin(a);
        write_ctrl(32'h200 | {23'd0, b});
        p0 = pulses;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); da_valid = 1'b1; da_first = (i == 0); da_byte = 8'hC3 + 8'(i);
        end
        send_addr(a, 0, '0);
        expect_verdict("R11 restart", a, 1, 1);
        check(pulses - p0 == 1, "R11 one pulse", pulses - p0, 1);
        // R11: unmarked bytes while idle
        p0 = pulses;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); da_valid = 1'b1; da_first = 1'b0; da_byte = a[8*(i%6) +: 8];
        end
        @(negedge clk); da_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(pulses == p0, "R11 unmarked ignored", pulses - p0, 0);

        summary();
    end

endmodule